// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a pre-selected, pre-divided functional clock into the strobes that a UART's transmit and receive shifters use. A programmable integer divisor sets the spacing of sample strobes. A 4-bit fractional trim spreads a few extra clock cycles across every sixteen bits, which gives rates between the integer steps. An oversampling selector chooses either 16 or 4 sample strobes per bit. A second strobe marks the end of each bit.

The block also produces the enable for its own clock. While the processor is halted for debug, the whole generator freezes, unless a debug-run control keeps it going. Nothing is lost during a freeze: counters, strobes and the latched configuration resume exactly where they stopped. Configuration is read only at bit boundaries, so software may rewrite it at any time without corrupting the bit in flight.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset is released, both strobes are low and the gate output is high while no debug halt is present.
- R2: With no fractional stretch, consecutive sample strobes are `brt_i`+1 functional-clock cycles apart (`brt_i` from 0 to 255).
- R3: When `os4_i` is 0 each bit holds 16 sample strobes; when it is 1 each bit holds 4.
- R4: The bit strobe is high only together with a sample strobe, and it marks the last sample of each bit.
- R5: Over any 16 consecutive bits with a constant fraction `fmd_i`, exactly `fmd_i` extra cycles are inserted, at most one per bit, each added to the last sample of its bit. The first bit after enable is never stretched.
- R6: While `en_i` is low, all counters and the fraction accumulator are zero and both strobes are low. The first sample strobe appears `brt_i`+1 cycles after the first rising clock edge that samples `en_i` high.
- R7: While enabled, `brt_i`, `fmd_i` and `os4_i` are latched only at a bit boundary, so a change during a bit takes effect from the next bit. While disabled, the latched configuration follows the inputs.
- R8: When `dbg_halt_i` is 1 and `dbg_run_i` is 0, `clk_gate_o` is low. Every counter, strobe and latched setting then holds its value, and counting resumes unchanged once the halt clears.
- R9: When `dbg_run_i` is 1, `clk_gate_o` stays high and the generator keeps counting through a debug halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock, already selected and divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable; low clears counters |
| brt_i | input | 8 | Integer divisor; sample period is value+1 cycles |
| fmd_i | input | 4 | Fractional trim: extra cycles per 16 bits |
| os4_i | input | 1 | Oversampling select: 0 = 16 samples/bit, 1 = 4 samples/bit |
| dbg_halt_i | input | 1 | Processor is in debug state |
| dbg_run_i | input | 1 | Keep running during debug state |
| clk_gate_o | output | 1 | Enable for this block's clock |
| sample_tick_o | output | 1 | Sample strobe |
| bit_tick_o | output | 1 | End-of-bit strobe |

## Verification
A wrong divider count or a misplaced stretch changes when the next sample strobe arrives, so it shows up within one sample period. An accumulator fault may stay hidden for up to sixteen bits, and only the total length of a sixteen-bit group exposes it. For that reason the bench measures whole groups against the closed-form cycle count. A configuration latched too early shortens the bit in flight, which shows on the very next bit strobe. A freeze that leaks lets a strobe move while the gate is low, or lengthens the group by less than the frozen cycles.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic {OS_X16 = 1'b0, OS_X4 = 1'b1} os_sel_e;

  localparam int unsigned SampW = 4;

  function automatic logic [SampW-1:0] last_samp(os_sel_e s);
    return (s == OS_X4) ? SampW'(3) : SampW'(15);
  endfunction
endpackage

// File: rtl/brg_gate.sv
module brg_gate (
  input  logic dbg_halt_i,
  input  logic dbg_run_i,
  output logic run_o
);
  assign run_o = ~dbg_halt_i | dbg_run_i;
endmodule

// File: rtl/brg_cfg.sv
module brg_cfg
  import fbg_pkg::*;
#(
  parameter int unsigned BrtW = 8,
  parameter int unsigned FmdW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BrtW-1:0] brt_i,
  input  logic [FmdW-1:0] fmd_i,
  input  logic            os4_i,
  output logic [BrtW-1:0] brt_o,
  output logic [FmdW-1:0] fmd_o,
  output os_sel_e         os_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brt_o <= '0;
      fmd_o <= '0;
      os_o  <= OS_X16;
    end else if (load_i) begin
      brt_o <= brt_i;
      fmd_o <= fmd_i;
      os_o  <= os_sel_e'(os4_i);
    end
  end

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(brt_o) && $stable(fmd_o) && $stable(os_o)));
endmodule

// File: rtl/brg_frac.sv
module brg_frac #(
  parameter int unsigned FmdW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [FmdW-1:0] fmd_i,
  output logic            stretch_o
);
  logic [FmdW-1:0] acc_q;
  logic [FmdW:0]   sum;

  assign sum       = {1'b0, acc_q} + {1'b0, fmd_i};
  assign stretch_o = sum[FmdW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (adv_i) acc_q <= sum[FmdW-1:0];
  end

  p_acc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i || adv_i) |=> $stable(acc_q));
  p_acc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
endmodule

// File: rtl/brg_div.sv
module brg_div
  import fbg_pkg::*;
#(
  parameter int unsigned BrtW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            en_i,
  input  logic [BrtW-1:0] brt_i,
  input  os_sel_e         os_i,
  input  logic            stretch_i,
  output logic            samp_tick_o,
  output logic            bit_tick_o,
  output logic            bit_end_o
);
  localparam int unsigned CntW = BrtW + 1;

  logic [CntW-1:0]  div_cnt_q;
  logic [SampW-1:0] samp_cnt_q;
  logic [CntW-1:0]  lim;
  logic             is_last, at_lim;

  assign is_last   = (samp_cnt_q == last_samp(os_i));
  // stretch lands on the last sample of the bit
  assign lim       = {1'b0, brt_i} + CntW'(is_last & stretch_i);
  assign at_lim    = (div_cnt_q == lim);
  assign bit_end_o = run_i & en_i & at_lim & is_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q   <= '0;
      samp_cnt_q  <= '0;
      samp_tick_o <= 1'b0;
      bit_tick_o  <= 1'b0;
    end else if (run_i) begin
      if (!en_i) begin
        div_cnt_q   <= '0;
        samp_cnt_q  <= '0;
        samp_tick_o <= 1'b0;
        bit_tick_o  <= 1'b0;
      end else begin
        samp_tick_o <= at_lim;
        bit_tick_o  <= at_lim & is_last;
        if (at_lim) begin
          div_cnt_q  <= '0;
          samp_cnt_q <= is_last ? '0 : samp_cnt_q + 1'b1;
        end else begin
          div_cnt_q  <= div_cnt_q + 1'b1;
        end
      end
    end
  end

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(div_cnt_q) && $stable(samp_cnt_q) &&
                $stable(samp_tick_o) && $stable(bit_tick_o)));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !en_i) |=> (div_cnt_q == '0 && samp_cnt_q == '0 &&
                          !samp_tick_o && !bit_tick_o));
  p_bit_on_samp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> samp_tick_o);
  p_div_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_cnt_q <= ({1'b0, brt_i} + CntW'(1)));
  p_samp_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_cnt_q <= last_samp(os_i));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int unsigned BrtW = 8,
  parameter int unsigned FmdW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [BrtW-1:0] brt_i,
  input  logic [FmdW-1:0] fmd_i,
  input  logic            os4_i,
  input  logic            dbg_halt_i,
  input  logic            dbg_run_i,
  output logic            clk_gate_o,
  output logic            sample_tick_o,
  output logic            bit_tick_o
);
  logic            run, bit_end, stretch;
  logic [BrtW-1:0] brt_sh;
  logic [FmdW-1:0] fmd_sh;
  os_sel_e         os_sh;

  brg_gate i_gate (
    .dbg_halt_i (dbg_halt_i),
    .dbg_run_i  (dbg_run_i),
    .run_o      (run)
  );

  brg_cfg #(.BrtW(BrtW), .FmdW(FmdW)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (run & (~en_i | bit_end)),
    .brt_i  (brt_i),
    .fmd_i  (fmd_i),
    .os4_i  (os4_i),
    .brt_o  (brt_sh),
    .fmd_o  (fmd_sh),
    .os_o   (os_sh)
  );

  brg_frac #(.FmdW(FmdW)) i_frac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (run & ~en_i),
    .adv_i     (bit_end),
    .fmd_i     (fmd_sh),
    .stretch_o (stretch)
  );

  brg_div #(.BrtW(BrtW)) i_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .en_i        (en_i),
    .brt_i       (brt_sh),
    .os_i        (os_sh),
    .stretch_i   (stretch),
    .samp_tick_o (sample_tick_o),
    .bit_tick_o  (bit_tick_o),
    .bit_end_o   (bit_end)
  );

  assign clk_gate_o = run;

  p_dbg_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_run_i && en_i && bit_end) |=> bit_tick_o);
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] brt = '0;
  logic [3:0] fmd = '0;
  logic       os4 = 1'b0;
  logic       halt = 1'b0;
  logic       drun = 1'b0;
  logic       gate, stk, btk;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .brt_i (brt), .fmd_i (fmd),
    .os4_i (os4), .dbg_halt_i (halt), .dbg_run_i (drun),
    .clk_gate_o (gate), .sample_tick_o (stk), .bit_tick_o (btk)
  );

  typedef struct packed {
    logic [7:0]  brt;
    logic [3:0]  fmd;
    logic        os4;
    logic [15:0] cyc;
    logic [8:0]  smp;
  } vec_t;

  // cyc = 16 * samples_per_bit * (brt+1) + fmd, over 16 bits
  localparam vec_t VEC [5] = '{
    '{8'd3,   4'd0,  1'b0, 16'd1024,  9'd256},
    '{8'd0,   4'd5,  1'b1, 16'd69,    9'd64},
    '{8'd9,   4'd15, 1'b0, 16'd2575,  9'd256},
    '{8'd255, 4'd7,  1'b1, 16'd16391, 9'd64},
    '{8'd1,   4'd8,  1'b0, 16'd520,   9'd256}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_case(input logic [7:0] b, input logic [3:0] f, input logic o,
                          input int nbits, input int frz_at, input int frz_len,
                          input logic frz_run, input int chg_at, input logic [7:0] chg_brt,
                          output int k, output int s);
    int   nb;
    logic g_prev, st_h, bt_h;
    en = 1'b0; halt = 1'b0; drun = 1'b0; brt = b; fmd = f; os4 = o;
    @(negedge clk); @(negedge clk);
    en = 1'b1; k = 0; s = 0; nb = 0; g_prev = 1'b1; st_h = 1'b0; bt_h = 1'b0;
    while (nb < nbits && k < 40000) begin
      @(negedge clk);
      k++;
      if (g_prev && stk) s++;
      if (g_prev && btk) nb++;
      if (!g_prev) chk(stk == st_h && btk == bt_h, "R8 hold", {stk, btk}, {st_h, bt_h});
      if (k == frz_at) begin
        halt = 1'b1; drun = frz_run; st_h = stk; bt_h = btk;
        #1 chk(gate == frz_run, frz_run ? "R9 gate" : "R8 gate", gate, frz_run);
      end
      if (k == frz_at + frz_len) halt = 1'b0;
      if (k == chg_at) brt = chg_brt;
      #1 g_prev = gate;
    end
    en = 1'b0; halt = 1'b0; drun = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int k, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stk == 1'b0, "R1 sample", stk, 0);
    chk(btk == 1'b0, "R1 bit", btk, 0);
    chk(gate == 1'b1, "R1 gate", gate, 1);

    // R2 R3 R5 table walk
    foreach (VEC[i]) begin
      run_case(VEC[i].brt, VEC[i].fmd, VEC[i].os4, 16, -1, 0, 1'b0, -1, 8'd0, k, s);
      chk(k == int'(VEC[i].cyc), "R2/R5 16-bit length", k, VEC[i].cyc);
      chk(s == int'(VEC[i].smp), "R3 samples per 16 bits", s, VEC[i].smp);
    end

    // R6 first sample strobe brt+1 cycles after enable
    en = 1'b0; brt = 8'd4; fmd = '0; os4 = 1'b0;
    @(negedge clk); @(negedge clk);
    en = 1'b1; k = 0;
    do begin @(negedge clk); k++; end while (!stk && k < 100);
    chk(k == 5, "R6 first strobe", k, 5);
    repeat (7) @(negedge clk);
    en = 1'b0;
    s = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (stk || btk) s++;
    end
    chk(s == 0, "R6 disabled strobes", s, 0);

    // R4 bit strobe on last sample: first bit at 16*(brt+1)
    run_case(8'd2, 4'd0, 1'b0, 1, -1, 0, 1'b0, -1, 8'd0, k, s);
    chk(k == 48 && s == 16, "R4 first bit strobe", k, 48);

    // R8 freeze adds exactly the frozen cycles
    run_case(8'd2, 4'd3, 1'b0, 16, 100, 50, 1'b0, -1, 8'd0, k, s);
    chk(k == 821, "R8 frozen length", k, 821);
    chk(s == 256, "R8 samples", s, 256);

    // R9 debug-run keeps counting
    run_case(8'd2, 4'd3, 1'b0, 16, 100, 50, 1'b1, -1, 8'd0, k, s);
    chk(k == 771, "R9 run-through length", k, 771);

    // R7 divisor change mid-bit: 40 old cycles then 4*2 new
    run_case(8'd9, 4'd0, 1'b1, 2, -1, 0, 1'b0, 10, 8'd1, k, s);
    chk(k == 48, "R7 deferred change", k, 48);
    chk(s == 8, "R7 samples", s, 8);

    summary();
  end
endmodule